// File: doc/BRIEF.md
# Keyed First-Come Slot Arbiter

This block settles conflicts among a fixed set of requesters that each name one slot out of a small slot pool. Every requester drives an active flag and a slot key. Requesters are ranked by index, lowest first. For each slot, the lowest-ranked active requester naming that slot is granted and every later claimant of the same slot is refused. The block returns a grant vector with one bit per requester and a mask with one bit per slot that is occupied after arbitration.

The grant for requester j is a flat OR-reduction of key-equality terms against every lower-ranked requester, followed by one AND gate. The logic depth therefore grows with the logarithm of the requester count. It does not grow with the product of requester count and slot count, as a loop that walks a one-hot occupancy vector does. The slot count need not be a power of two. A key at or above the slot count names no slot: it is never granted, it never blocks anyone and it never shows in the mask. A parameter can mark requesters as permanently active, so that they compete regardless of their flag. A second parameter chooses between purely combinational outputs and outputs held in a register with a synchronous reset.

Top module: `prio_key_dedup`

## Requirements
- R1: With the registered output mode, a high `rst` at a rising edge clears `grant` and `taken` to all zeros at that edge.
- R2: Requester 0 is granted whenever it is active and its key is below S.
- R3: Requester j (key in bits [j*KW +: KW] of `key_in`) is granted exactly when it is active, its key is below S, and no lower-indexed requester is active with the same in-range key.
- R4: A requester whose key is S or above is never granted, never blocks any other requester, and sets no bit of `taken`.
- R5: Bit k of `taken` is 1 exactly when some granted requester carries key k. Bits at or above the slot count do not exist, so the count of ones in `taken` equals the count of ones in `grant`.
- R6: No two granted requesters carry the same key.
- R7: In registered mode, the outputs at an edge reflect the inputs sampled at the previous edge. In combinational mode they follow the current inputs with no clock.
- R8: A requester whose bit is set in parameter ALWAYS_ACT is treated as active whatever the value of its `act` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output mode |
| rst | input | 1 | Synchronous active-high reset of the output register |
| act | input | P | Active flag per requester, bit i for requester i |
| key_in | input | P*KW | Slot keys, requester i in bits [i*KW +: KW] |
| grant | output | P | Grant per requester |
| taken | output | S | Occupied-slot mask, bit k for slot k |

## Verification
The bench sweeps every active vector of eight requesters against several key layouts and checks each against a serial occupancy-loop model. The layouts are: all requesters colliding on one key, all keys distinct, three-way collision groups, keys at the boundary S-1 and S, and out-of-range keys mixed with in-range ones. A design that let an out-of-range key block others would drop a valid grant, and one that compared keys only against winners instead of all active predecessors would still agree, which the collision layouts confirm. An off-by-one range test would grant slot S or suppress slot S-1. A missing pipeline stage, or a reset that leaves stale grants, would show up on the registered instance. The combinational instance carries a forced-active requester, which must claim its slot even while its flag is low.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/pkd_cand.sv
module pkd_cand #(
    parameter int           P          = 8,
    parameter int           S          = 12,
    parameter int           KW         = 4,
    parameter logic [P-1:0] ALWAYS_ACT = '0
) (
    input  logic [P-1:0]    act,
    input  logic [P*KW-1:0] key_in,
    output logic [P-1:0]    cand
);
    localparam logic [KW:0] LIMIT = (KW+1)'(S);

    for (genvar i = 0; i < P; i++) begin : g_src
        logic in_range;
        assign in_range = {1'b0, key_in[i*KW +: KW]} < LIMIT;
        assign cand[i]  = (act[i] | ALWAYS_ACT[i]) & in_range;
    end
endmodule

// File: rtl/pkd_block.sv
module pkd_block #(
    parameter int P  = 8,
    parameter int KW = 4
) (
    input  logic [P-1:0]    cand,
    input  logic [P*KW-1:0] key_in,
    output logic [P-1:0]    blocked
);
    assign blocked[0] = 1'b0;

    for (genvar j = 1; j < P; j++) begin : g_dst
        logic [j-1:0] hit;
        for (genvar i = 0; i < j; i++) begin : g_pair
            assign hit[i] = cand[i] & (key_in[i*KW +: KW] == key_in[j*KW +: KW]);
        end
        assign blocked[j] = |hit;
    end
endmodule

// File: rtl/pkd_mask.sv
module pkd_mask #(
    parameter int P  = 8,
    parameter int S  = 12,
    parameter int KW = 4
) (
    input  logic [P-1:0]    grant,
    input  logic [P*KW-1:0] key_in,
    output logic [S-1:0]    taken
);
    for (genvar k = 0; k < S; k++) begin : g_slot
        logic [P-1:0] own;
        for (genvar i = 0; i < P; i++) begin : g_src
            assign own[i] = grant[i] & (key_in[i*KW +: KW] == KW'(k));
        end
        assign taken[k] = |own;
    end
endmodule

// File: rtl/prio_key_dedup.sv
module prio_key_dedup #(
    parameter int                P          = 8,
    parameter int                S          = 12,
    parameter int                KW         = 4,
    parameter pkd_pkg::out_mode_e MODE      = pkd_pkg::OUT_REG,
    parameter logic [P-1:0]      ALWAYS_ACT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [P-1:0]     act,
    input  logic [P*KW-1:0]  key_in,
    output logic [P-1:0]     grant,
    output logic [S-1:0]     taken
);
    typedef struct packed {
        logic [P-1:0] grant;
        logic [S-1:0] taken;
    } res_t;

    logic [P-1:0] cand;
    logic [P-1:0] blocked;
    logic [P-1:0] grant_c;
    logic [S-1:0] taken_c;
    res_t         res_d;

    pkd_cand #(.P(P), .S(S), .KW(KW), .ALWAYS_ACT(ALWAYS_ACT)) u_cand (
        .act    (act),
        .key_in (key_in),
        .cand   (cand)
    );

    pkd_block #(.P(P), .KW(KW)) u_block (
        .cand    (cand),
        .key_in  (key_in),
        .blocked (blocked)
    );

    assign grant_c = cand & ~blocked;

    pkd_mask #(.P(P), .S(S), .KW(KW)) u_mask (
        .grant  (grant_c),
        .key_in (key_in),
        .taken  (taken_c)
    );

    always_comb begin
        res_d       = '0;
        res_d.grant = grant_c;
        res_d.taken = taken_c;
    end

    if (MODE == pkd_pkg::OUT_REG) begin : g_reg
        res_t res_q;
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= res_d;
        end
        assign grant = res_q.grant;
        assign taken = res_q.taken;
    end else begin : g_comb
        assign grant = res_d.grant;
        assign taken = res_d.taken;
    end
endmodule

// File: rtl/pkd_chk.sv
module pkd_chk #(
    parameter int                P          = 8,
    parameter int                S          = 12,
    parameter int                KW         = 4,
    parameter pkd_pkg::out_mode_e MODE      = pkd_pkg::OUT_REG,
    parameter logic [P-1:0]      ALWAYS_ACT = '0
) (
    input logic            clk,
    input logic            rst,
    input logic [P-1:0]    act,
    input logic [P*KW-1:0] key_in,
    input logic [P-1:0]    grant,
    input logic [S-1:0]    taken
);
    localparam bit          IS_REG = (MODE == pkd_pkg::OUT_REG);
    localparam logic [KW:0] LIMIT  = (KW+1)'(S);

    logic [P-1:0]    act_h;
    logic [P*KW-1:0] key_h;
    logic            hv;

    always_ff @(posedge clk) begin
        act_h <= act;
        key_h <= key_in;
        hv    <= !rst;
    end

    logic [P-1:0]    act_e;
    logic [P*KW-1:0] key_e;
    logic            ok;
    assign act_e = (IS_REG ? act_h : act) | ALWAYS_ACT;
    assign key_e = IS_REG ? key_h : key_in;
    assign ok    = IS_REG ? hv : 1'b1;

    // R2
    src0_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (ok && act_e[0] && ({1'b0, key_e[KW-1:0]} < LIMIT)) |-> grant[0]);

    // R5
    mask_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(taken) == $countones(grant));

    if (IS_REG) begin : g_rst
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> (grant == '0 && taken == '0));
    end

    for (genvar i = 0; i < P; i++) begin : g_src
        // R4
        oor_never_chk: assert property (@(posedge clk) disable iff (rst)
            (ok && ({1'b0, key_e[i*KW +: KW]} >= LIMIT)) |-> !grant[i]);
        // R3
        idle_never_chk: assert property (@(posedge clk) disable iff (rst)
            (ok && !act_e[i]) |-> !grant[i]);
        for (genvar j = i + 1; j < P; j++) begin : g_pair
            // R6
            unique_key_chk: assert property (@(posedge clk) disable iff (rst)
                (ok && grant[i] && grant[j]) |-> (key_e[i*KW +: KW] != key_e[j*KW +: KW]));
        end
    end
endmodule

bind prio_key_dedup pkd_chk #(
    .P(P), .S(S), .KW(KW), .MODE(MODE), .ALWAYS_ACT(ALWAYS_ACT)
) u_pkd_chk (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .key_in (key_in),
    .grant  (grant),
    .taken  (taken)
);

// File: tb/prio_key_dedup_bench.sv
module prio_key_dedup_bench;
    localparam int P  = 8;
    localparam int S  = 12;
    localparam int KW = 4;
    localparam logic [P-1:0] FORCE_C = 8'h04;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [P-1:0]    act = '0;
    logic [P*KW-1:0] key_in = '0;
    logic [P-1:0]    grant_r, grant_c;
    logic [S-1:0]    taken_r, taken_c;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    prio_key_dedup #(.P(P), .S(S), .KW(KW), .MODE(pkd_pkg::OUT_REG)) u_prio_key_dedup (
        .clk(clk), .rst(rst), .act(act), .key_in(key_in), .grant(grant_r), .taken(taken_r)
    );

    prio_key_dedup #(.P(P), .S(S), .KW(KW), .MODE(pkd_pkg::OUT_COMB), .ALWAYS_ACT(FORCE_C))
        u_prio_key_dedup_comb (
        .clk(clk), .rst(rst), .act(act), .key_in(key_in), .grant(grant_c), .taken(taken_c)
    );

    // Serial occupancy loop: reference behaviour from the requirements.
    function automatic void model(input logic [P-1:0] a, input logic [P*KW-1:0] k,
                                  output logic [P-1:0] g, output logic [S-1:0] t);
        g = '0;
        t = '0;
        for (int i = 0; i < P; i++) begin
            int kv;
            kv = int'(k[i*KW +: KW]);
            if (a[i] && kv < S && !t[kv]) begin
                g[i]  = 1'b1;
                t[kv] = 1'b1;
            end
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [P-1:0] g, input logic [S-1:0] t,
                             input logic [P-1:0] a, input logic [P*KW-1:0] k);
        logic [P-1:0] eg;
        logic [S-1:0] et;
        logic         dup;
        model(a, k, eg, et);
        check({tag, " R3"}, 32'(g), 32'(eg));
        check({tag, " R5"}, 32'(t), 32'(et));
        dup = 1'b0;
        for (int i = 0; i < P; i++)
            for (int j = i + 1; j < P; j++)
                if (g[i] && g[j] && k[i*KW +: KW] == k[j*KW +: KW]) dup = 1'b1;
        check({tag, " R6"}, 32'(dup), 32'd0);
        if (a[0] && int'(k[KW-1:0]) < S) check({tag, " R2"}, 32'(g[0]), 32'd1);
        for (int i = 0; i < P; i++)
            if (int'(k[i*KW +: KW]) >= S) check({tag, " R4"}, 32'(g[i]), 32'd0);
    endtask

    function automatic logic [P*KW-1:0] pattern(input int pat, input int seed);
        logic [P*KW-1:0] k;
        for (int i = 0; i < P; i++) begin
            case (pat)
                0: k[i*KW +: KW] = 4'd3;
                1: k[i*KW +: KW] = KW'(i);
                2: k[i*KW +: KW] = KW'(i % 3);
                3: k[i*KW +: KW] = (i % 2 == 0) ? 4'd15 : KW'(i / 2);
                4: k[i*KW +: KW] = (i < 4) ? 4'd11 : 4'd12;
                default: k[i*KW +: KW] = KW'((seed * 7 + i * 13 + (seed >> 3) * i) % 16);
            endcase
        end
        return k;
    endfunction

    initial begin
        logic [P-1:0]    pa;
        logic [P*KW-1:0] pk;
        logic            have_prev;
        pa = '0;
        pk = '0;
        have_prev = 1'b0;
        act    = '1;
        key_in = pattern(1, 0);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state of the registered outputs
        check("R1 reset grant", 32'(grant_r), 32'd0);
        check("R1 reset taken", 32'(taken_r), 32'd0);
        rst = 1'b0;
        for (int a = 0; a < 256; a++) begin
            for (int pat = 0; pat < 6; pat++) begin
                @(negedge clk);
                // R7: registered outputs reflect inputs applied one edge earlier
                if (have_prev) check_out("R7 reg", grant_r, taken_r, pa, pk);
                act    = P'(a);
                key_in = pattern(pat, a * 6 + pat);
                pa = act;
                pk = key_in;
                have_prev = 1'b1;
                #1;
                // R7 combinational path and R8 forced-active requester 2
                check_out("R7 R8 comb", grant_c, taken_c, act | FORCE_C, key_in);
            end
        end
        // R8: forced requester claims its slot even with all flags low
        @(negedge clk);
        act    = '0;
        key_in = pattern(1, 0);
        #1;
        check("R8 forced grant", 32'(grant_c), 32'h04);
        check("R8 forced slot", 32'(taken_c), 32'h004);
        // R1: mid-run reset clears a populated register
        @(negedge clk);
        act = '1;
        @(negedge clk);
        check("R1 pre-reset grant", 32'(grant_r), 32'hFF);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset grant", 32'(grant_r), 32'd0);
        check("R1 mid reset taken", 32'(taken_r), 32'd0);
        rst = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule